// File: doc/BRIEF.md
# Prioritised Bus Grant Arbiter for Multi-Channel DMA

This block decides which of several DMA channels drives a shared bus master port. Each channel presents a request, a programmable priority level, a flag telling whether it runs a memory-fill (initialisation) transfer, and two completion strobes: one for the last beat of the current burst and one for the last beat of the whole transfer. The arbiter keeps a registered one-hot grant. It picks a new owner only at well-defined release points. In normal block mode that is the end of a burst. In fill mode it is the end of the whole transfer, so a fill cannot be preempted.

A global freeze input halts the bus. While it is high the grant register keeps its value and the owner's bus request is masked. Freezing therefore stops all traffic without losing which channel owned the bus or where it stood, and releasing freeze resumes from the same owner.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `grant` is all zero and `bus_valid` is low.
- R2: `grant` is one-hot or all zero at all times.
- R3: At an arbitration point, the requesting channel with the numerically largest priority wins. Channel i's priority is `ch_prio[i*3 +: 3]`, where 7 is the highest level and 0 the lowest.
- R4: Among requesting channels with equal highest priority, the lowest channel index wins.
- R5: An arbitration point occurs only in these cases:
  - the grant is empty;
  - the owner's request is low;
  - in block mode, the owner's `ch_burst_end` bit is high.

  Burst-end and transfer-end strobes from channels that do not own the bus have no effect, and `ch_xfer_end` has no effect on a block-mode owner.
- R6: A channel whose `ch_init` bit is high in the cycle it wins keeps the grant through any number of burst ends and higher-priority requests. It releases only on its own `ch_xfer_end` or when its request drops.
- R7: While `freeze` is high, no arbitration takes place: `grant` is unchanged in the next cycle and all completion strobes are ignored.
- R8: The grant is registered. A winner selected at an arbitration point appears on `grant` one clock cycle later.
- R9: If no channel requests at an arbitration point, `grant` becomes all zero.
- R10: `bus_valid` is high exactly when the granted channel's request is high and `freeze` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freeze | input | 1 | Global halt; holds the grant and masks the bus request |
| ch_req | input | NCH | Per-channel bus request |
| ch_prio | input | NCH*PW | Per-channel priority; channel i in bits [i*PW +: PW], higher value wins |
| ch_init | input | NCH | Per-channel fill-mode flag, sampled when the channel wins |
| ch_burst_end | input | NCH | Per-channel strobe: last beat of the current burst accepted |
| ch_xfer_end | input | NCH | Per-channel strobe: last beat of the whole transfer accepted |
| grant | output | NCH | Registered one-hot bus grant |
| bus_valid | output | 1 | Owner's request forwarded to the bus, masked by freeze |

## Verification
The bench builds the block with its defaults: eight channels and three-bit priorities. These values give every priority level, including ties at 7 and at 0, and a tie-break that spans the full index range from channel 0 to channel 7. Random request, priority and strobe patterns drive the block into the corner cases below, each with a predicted next grant:
- fill owners that see repeated burst ends;
- freeze arriving in the same cycle as a release strobe;
- owners that drop their request mid-burst.

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NCH = 8,
  parameter int PW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            freeze,
  input  logic [NCH-1:0]  ch_req,
  input  logic [NCH*PW-1:0] ch_prio,
  input  logic [NCH-1:0]  ch_init,
  input  logic [NCH-1:0]  ch_burst_end,
  input  logic [NCH-1:0]  ch_xfer_end,
  output logic [NCH-1:0]  grant,
  output logic            bus_valid
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] grant_q;
  logic           lock_q;
  logic [NCH-1:0] win_oh;
  logic           win_any;
  logic [IW-1:0]  win_idx;
  logic [PW-1:0]  win_lvl;

  wire owner_req   = |(grant_q & ch_req);
  wire owner_burst = |(grant_q & ch_burst_end);
  wire owner_xend  = |(grant_q & ch_xfer_end);
  wire released    = (grant_q == '0) || !owner_req ||
                     (lock_q ? owner_xend : owner_burst);
  wire arb_now     = !freeze && released;
  wire win_init    = |(win_oh & ch_init);

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ch_req[i] && (!win_any || ch_prio[i*PW +: PW] >= win_lvl)) begin
        win_any = 1'b1;
        win_idx = IW'(i);
        win_lvl = ch_prio[i*PW +: PW];
      end
    end
    win_oh = '0;
    win_oh[win_idx] = win_any;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      lock_q  <= 1'b0;
    end else if (arb_now) begin
      grant_q <= win_oh;
      lock_q  <= win_any && win_init;
    end
  end

  assign grant     = grant_q;
  assign bus_valid = owner_req && !freeze;
endmodule

module dma_bus_arbiter_chk #(
  parameter int NCH = 8,
  parameter int PW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           freeze,
  input logic [NCH-1:0] ch_req,
  input logic [NCH-1:0] ch_burst_end,
  input logic [NCH-1:0] ch_xfer_end,
  input logic [NCH-1:0] grant,
  input logic           bus_valid,
  input logic           lock_q
);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(grant));

  a_r10_freeze_mask: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !bus_valid);

  a_r5_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && |(grant & ch_req) && !(|(grant & ch_burst_end))) |=> $stable(grant));

  a_r6_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && |(grant & ch_req) && !(|(grant & ch_xfer_end))) |=> $stable(grant));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && ch_req == '0) |=> grant == '0);

  a_r3_winner_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && grant != $past(grant)) |-> |($past(ch_req) & grant));
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NCH(NCH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze(freeze), .ch_req(ch_req),
  .ch_burst_end(ch_burst_end), .ch_xfer_end(ch_xfer_end),
  .grant(grant), .bus_valid(bus_valid), .lock_q(lock_q)
);

// File: tb/dma_bus_arbiter_test.sv
module dma_bus_arbiter_test;
  localparam int NCH = 8;
  localparam int PW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freeze = 1'b0;
  logic [NCH-1:0] ch_req = '0, ch_init = '0, ch_burst_end = '0, ch_xfer_end = '0;
  logic [NCH*PW-1:0] ch_prio = '0;
  logic [NCH-1:0] grant;
  logic bus_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [NCH-1:0] mg = '0;
  logic mlock = 1'b0;

  always #4 clk = ~clk;

  dma_bus_arbiter #(.NCH(NCH), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .ch_req(ch_req),
    .ch_prio(ch_prio), .ch_init(ch_init), .ch_burst_end(ch_burst_end),
    .ch_xfer_end(ch_xfer_end), .grant(grant), .bus_valid(bus_valid)
  );

  function automatic logic [NCH-1:0] pick(input logic [NCH-1:0] r, input logic [NCH*PW-1:0] p);
    logic [NCH-1:0] oh = '0;
    int best = -1;
    for (int i = 0; i < NCH; i++)
      if (r[i] && (best < 0 || int'(p[i*PW +: PW]) > int'(p[best*PW +: PW]))) best = i;
    if (best >= 0) oh[best] = 1'b1;
    return oh;
  endfunction

  task automatic check(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic [NCH-1:0] eg = mg;
    logic el = mlock;
    bit rel;
    rel = (mg == '0) || !(|(mg & ch_req)) ||
          (mlock ? |(mg & ch_xfer_end) : |(mg & ch_burst_end));
    if (!freeze && rel) begin
      eg = pick(ch_req, ch_prio);
      el = |(eg & ch_init);
    end
    @(posedge clk); #1;
    mg = eg; mlock = el;
    check({tag, " grant"}, grant, mg);
    check({tag, " R10 bus_valid"}, NCH'(bus_valid), NCH'(|(mg & ch_req) && !freeze));
  endtask

  task automatic setp(input int ch, input int lvl);
    ch_prio[ch*PW +: PW] = PW'(lvl);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    ch_req = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset grant", grant, '0);
    check("R1 reset bus_valid", NCH'(bus_valid), '0);
    ch_req = '0;
    rst_n = 1'b1;
    step("R1 after reset");

    setp(2, 5); setp(6, 7);
    ch_req = 8'b0100_0100;
    step("R3 R8 highest level");
    setp(1, 7);
    ch_req = 8'b0100_0110;
    ch_burst_end = 8'b0000_0010;
    step("R5 non-owner strobe ignored");
    ch_burst_end = 8'b0100_0000;
    step("R4 tie lowest index");
    ch_burst_end = '0;
    freeze = 1'b1;
    ch_burst_end = 8'b0000_0010;
    step("R7 freeze holds");
    freeze = 1'b0;
    ch_burst_end = '0;
    ch_req = '0;
    step("R9 idle");

    setp(3, 1); setp(0, 7);
    ch_init = 8'b0000_1000;
    ch_req = 8'b0000_1000;
    step("R6 fill win");
    ch_req = 8'b0000_1001;
    ch_burst_end = 8'b0000_1000;
    step("R6 burst end ignored in fill");
    step("R6 still locked");
    ch_burst_end = '0;
    ch_xfer_end = 8'b0000_1000;
    step("R6 release on transfer end");
    ch_xfer_end = 8'b0000_0001;
    ch_init = '0;
    step("R5 xfer_end ignored in block mode");
    ch_xfer_end = '0;
    ch_req = '0;
    step("R9 idle again");

    for (int n = 0; n < 3000; n++) begin
      ch_req = '0; ch_init = '0; ch_burst_end = '0; ch_xfer_end = '0;
      for (int c = 0; c < NCH; c++) begin
        ch_req[c]       = ($urandom_range(99) < 60);
        ch_init[c]      = ($urandom_range(99) < 20);
        ch_burst_end[c] = ($urandom_range(99) < 30);
        ch_xfer_end[c]  = ($urandom_range(99) < 15);
        setp(c, int'($urandom_range(7)));
      end
      freeze = ($urandom_range(99) < 10);
      step("R2 R3 R4 R5 R6 R7 random");
    end
    finish_run();
  end
endmodule